// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block sits on the controller side of an asynchronous EDO DRAM and turns single-word requests into strobe sequences. A request carries a row, a column, a direction flag and write data. It is taken on a valid/ready handshake. The sequencer drives the multiplexed address and the active-low row strobe, column strobe, write enable and output enable. It also drives the enable of the write data bus, and it returns read data with a one-cycle valid pulse.

Once a row is open, a request that targets the same row and arrives at the end of the column-strobe high time is served without closing the row. Only the column strobe toggles again, with the new column on the address pins. A request to another row, an empty request input, or the row-open time limit closes the row. The row strobe then stays high for a precharge time before the next row opens. Output enable is low only while the column strobe is low during a read. Because an EDO part keeps driving its data after the column strobe rises, this holds the part's outputs off between column accesses and while the controller drives the bus. All timing values are counts of the system clock.

Top module: `edo_page_seq`

## Requirements
- R1: While reset is held and on leaving it, the row strobe, column strobe, write enable and output enable are all high (inactive), the data bus enable and read-valid are low, and the request input is ready.
- R2: A request accepted while no row is open makes the row strobe fall on the next cycle with the request's row on the address pins. The column strobe then stays high for T_RCD cycles while the row strobe is low.
- R3: After the row strobe has been low for T_RAH cycles, the address pins carry the column, zero-extended, until the row strobe rises.
- R4: Each column-strobe low pulse lasts exactly T_CAS cycles and is followed by T_CP cycles with the column strobe high.
- R5: A request to the open row is accepted only in the last column-strobe-high cycle. The column strobe then falls again on the next cycle while the row strobe stays low.
- R6: When no qualifying request is present in the last column-strobe-high cycle, the row strobe rises and stays high for at least T_RP cycles. The next request is taken only after that.
- R7: A same-row request is refused, and the row closed and later reopened, if serving it would keep the row strobe low for more than T_RAS_MAX cycles. The row strobe is never low for more than T_RAS_MAX consecutive cycles.
- R8: Output enable is low only during column-strobe-low cycles of a read. It is high in every cycle in which the column strobe is high.
- R9: For a read, read-valid pulses for one cycle in the first column-strobe-high cycle. The read data then equals the DRAM data input sampled in the last column-strobe-low cycle, and it holds that value until the next read.
- R10: For a write, write enable is low from the row-open cycles (or the column cycle on a page hit) through the column-strobe-low cycles. The bus enable is high with the write data on the bus while the row is open for that write, including its column-strobe-high cycles. Output enable is never low while the bus enable is high.
- R11: The ready output is high only when no row is open and no precharge is running, or in the last column-strobe-high cycle together with a qualifying same-row request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse with new read data |
| rd_data | output | DATA_W | Last read word |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the data bus driver |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
A wrong phase counter or state shows within one clock as a strobe edge in the wrong cycle. A stale open-row register or age count shows as a page hit that should have been a reopen, or the reverse. That is visible at the ready output in the last column-high cycle and on the row strobe one cycle later. A slip in the read capture point gives a read word from a neighbouring cycle of the changing data input. The reference model compares every output on every clock, so the first cycle of divergence is reported.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_CASH = 3'd3,
        ST_PRE  = 3'd4
    } seq_state_e;

    function automatic logic row_open(input seq_state_e s);
        return (s == ST_ROW) || (s == ST_COL) || (s == ST_CASH);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/edo_seq_addr_mux.sv
module edo_seq_addr_mux #(
    parameter int ROW_W = 12,
    parameter int COL_W = 10,
    parameter int AGE_W = 5,
    parameter int T_RAH = 1,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              open_i,
    input  logic [AGE_W-1:0]  age_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic use_col;

    always_comb begin
        use_col = open_i && (32'(age_i) >= T_RAH);
        if (use_col) addr_o = ADDR_W'(col_i);
        else         addr_o = ADDR_W'(row_i);
    end
endmodule

// File: rtl/edo_seq_strobe_dec.sv
module edo_seq_strobe_dec
    import edo_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       wr_i,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic       we_n_o,
    output logic       oe_n_o,
    output logic       dq_oe_o
);
    always_comb begin
        ras_n_o = !row_open(state_i);
        cas_n_o = (state_i != ST_COL);
        oe_n_o  = !((state_i == ST_COL) && !wr_i);
        we_n_o  = !(wr_i && ((state_i == ST_ROW) || (state_i == ST_COL)));
        dq_oe_o = wr_i && row_open(state_i);
    end
endmodule

// File: rtl/edo_seq_page_gate.sv
module edo_seq_page_gate #(
    parameter int ROW_W     = 12,
    parameter int AGE_W     = 5,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_RAS_MAX = 24
) (
    input  logic [ROW_W-1:0] req_row_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic [AGE_W-1:0] age_i,
    output logic             hit_ok_o
);
    localparam int EXTRA = 1 + T_CAS + T_CP;
    logic same_row;
    logic fits;

    always_comb begin
        same_row = (req_row_i == open_row_i);
        fits     = (32'(age_i) + EXTRA) <= T_RAS_MAX;
        hit_ok_o = same_row && fits;
    end
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 16,
    parameter int T_RCD     = 3,
    parameter int T_RAH     = 1,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 24,
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int T_MAX = max4(T_RCD, T_CAS, T_CP, T_RP);
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int AGE_W = $clog2(T_RAS_MAX + 2);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [AGE_W-1:0]  age;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_t;

    seq_t seq_q, seq_d;
    logic hit_ok;
    logic last_cnt;
    logic page_take;

    edo_seq_page_gate #(
        .ROW_W(ROW_W), .AGE_W(AGE_W), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX)
    ) u_gate (
        .req_row_i  (req_row),
        .open_row_i (seq_q.row),
        .age_i      (seq_q.age),
        .hit_ok_o   (hit_ok)
    );

    edo_seq_strobe_dec u_dec (
        .state_i (seq_q.state),
        .wr_i    (seq_q.wr),
        .ras_n_o (dram_ras_n),
        .cas_n_o (dram_cas_n),
        .we_n_o  (dram_we_n),
        .oe_n_o  (dram_oe_n),
        .dq_oe_o (dram_dq_oe)
    );

    edo_seq_addr_mux #(
        .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W), .T_RAH(T_RAH)
    ) u_amux (
        .open_i (row_open(seq_q.state)),
        .age_i  (seq_q.age),
        .row_i  (seq_q.row),
        .col_i  (seq_q.col),
        .addr_o (dram_addr)
    );

    always_comb begin
        last_cnt  = (seq_q.cnt == '0);
        page_take = (seq_q.state == ST_CASH) && last_cnt && req_valid && hit_ok;
        req_ready = (seq_q.state == ST_IDLE) || page_take;

        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;

        case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.state = ST_ROW;
                    seq_d.cnt   = CNT_W'(T_RCD - 1);
                    seq_d.row   = req_row;
                    seq_d.col   = req_col;
                    seq_d.wr    = req_write;
                    seq_d.wdata = req_wdata;
                end
            end
            ST_ROW: begin
                if (last_cnt) begin
                    seq_d.state = ST_COL;
                    seq_d.cnt   = CNT_W'(T_CAS - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (last_cnt) begin
                    if (!seq_q.wr) begin
                        seq_d.rdata  = dram_dq_in;
                        seq_d.rvalid = 1'b1;
                    end
                    seq_d.state = ST_CASH;
                    seq_d.cnt   = CNT_W'(T_CP - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_CASH: begin
                if (page_take) begin
                    seq_d.state = ST_COL;
                    seq_d.cnt   = CNT_W'(T_CAS - 1);
                    seq_d.col   = req_col;
                    seq_d.wr    = req_write;
                    seq_d.wdata = req_wdata;
                end else if (last_cnt) begin
                    seq_d.state = ST_PRE;
                    seq_d.cnt   = CNT_W'(T_RP - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (last_cnt) seq_d.state = ST_IDLE;
                else          seq_d.cnt   = seq_q.cnt - 1'b1;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase

        if (row_open(seq_d.state) && row_open(seq_q.state)) seq_d.age = seq_q.age + 1'b1;
        else                                                seq_d.age = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_valid    = seq_q.rvalid;
    assign rd_data     = seq_q.rdata;
    assign dram_dq_out = seq_q.wdata;

endmodule

// File: rtl/edo_seq_checker.sv
module edo_seq_checker #(
    parameter int T_CAS     = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 24
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic rd_valid
);
    int ras_low_run;
    int ras_high_run;
    int cas_low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_low_run  <= 0;
            ras_high_run <= T_RP;
            cas_low_run  <= 0;
        end else begin
            ras_low_run  <= ras_n ? 0 : ras_low_run + 1;
            ras_high_run <= ras_n ? ras_high_run + 1 : 0;
            cas_low_run  <= cas_n ? 0 : cas_low_run + 1;
        end
    end

    assert_ras_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (ras_low_run < T_RAS_MAX));

    assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_high_run >= T_RP));

    assert_cas_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (cas_low_run == T_CAS));

    assert_cas_in_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> !ras_n);

    assert_oe_off_cas_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |-> oe_n);

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && ($countones({we_n, oe_n}) >= 1)));

    assert_rd_after_cas_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(cas_n));

endmodule

bind edo_page_seq edo_seq_checker #(
    .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .oe_n     (dram_oe_n),
    .dq_oe    (dram_dq_oe),
    .rd_valid (rd_valid)
);

// File: tb/tb_edo_page_seq.sv
module tb_edo_page_seq;
    localparam int ROW_W = 12, COL_W = 10, DATA_W = 16;
    localparam int T_RCD = 3, T_RAH = 1, T_CAS = 2, T_CP = 2, T_RP = 3, T_RAS_MAX = 24;
    localparam int ADDR_W = 12;
    localparam int NREQ = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DATA_W-1:0] dram_dq_out;
    logic [DATA_W-1:0] dram_dq_in = 16'h1234;

    always #2 clk = ~clk;

    edo_page_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // Reference model: phase 0 idle, 1 row open, 2 column low, 3 column high, 4 precharge
    int ph = 0, left = 0, age = 0;
    int m_row = 0, m_col = 0, m_wr = 0, m_wd = 0, m_rd = 0, m_rv = 0;
    bit last_acc = 0;
    int ras_falls = 0, cas_falls = 0, rd_pulses = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;

    function automatic bit model_ready();
        if (ph == 0) return 1;
        return (ph == 3) && (left == 0) && req_valid && (int'(req_row) == m_row)
               && (age + 1 + T_CAS + T_CP <= T_RAS_MAX);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; left = 0; age = 0; m_rv = 0; m_rd = 0; m_wr = 0; last_acc = 0;
        end else begin
            automatic bit acc = req_valid && model_ready();
            automatic int old = ph;
            last_acc = acc;
            m_rv = 0;
            case (ph)
                0: if (acc) begin
                       ph = 1; left = T_RCD - 1;
                       m_row = int'(req_row); m_col = int'(req_col);
                       m_wr = int'(req_write); m_wd = int'(req_wdata);
                   end
                1: if (left == 0) begin ph = 2; left = T_CAS - 1; end else left--;
                2: if (left == 0) begin
                       if (m_wr == 0) begin m_rd = int'(dram_dq_in); m_rv = 1; end
                       ph = 3; left = T_CP - 1;
                   end else left--;
                3: if (acc) begin
                       ph = 2; left = T_CAS - 1;
                       m_col = int'(req_col); m_wr = int'(req_write); m_wd = int'(req_wdata);
                   end else if (left == 0) begin ph = 4; left = T_RP - 1; end
                   else left--;
                default: if (left == 0) ph = 0; else left--;
            endcase
            if (ph >= 1 && ph <= 3 && old >= 1 && old <= 3) age++;
            else age = 0;
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            automatic bit open = (ph >= 1 && ph <= 3);
            automatic int e_addr = (open && age >= T_RAH) ? m_col : m_row;
            automatic int e_dqoe = (m_wr != 0 && open) ? 1 : 0;
            chk("R6 ras_n", int'(dram_ras_n), open ? 0 : 1);
            chk("R4 cas_n", int'(dram_cas_n), (ph == 2) ? 0 : 1);
            chk("R3 addr", int'(dram_addr), e_addr);
            chk("R8 oe_n", int'(dram_oe_n), (ph == 2 && m_wr == 0) ? 0 : 1);
            chk("R10 we_n", int'(dram_we_n), (m_wr != 0 && (ph == 1 || ph == 2)) ? 0 : 1);
            chk("R10 dq_oe", int'(dram_dq_oe), e_dqoe);
            if (e_dqoe != 0) chk("R10 dq_out", int'(dram_dq_out), m_wd);
            chk("R11 ready", int'(req_ready), int'(model_ready()));
            chk("R9 rd_valid", int'(rd_valid), m_rv);
            chk("R9 rd_data", int'(rd_data), m_rd);
            if (prev_ras && !dram_ras_n) begin
                ras_falls++;
                chk("R2 row addr at ras fall", int'(dram_addr), m_row);
            end
            if (prev_cas && !dram_cas_n) cas_falls++;
            if (rd_valid) rd_pulses++;
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    always @(negedge clk) dram_dq_in <= dram_dq_in * 16'd5 + 16'h3a1;

    task automatic send(input int row, input int col, input bit wr, input int wd);
        req_valid = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(col);
        req_write = wr; req_wdata = DATA_W'(wd);
        forever begin
            @(negedge clk);
            if (last_acc) break;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ras_n in reset", int'(dram_ras_n), 1);
        chk("R1 cas_n in reset", int'(dram_cas_n), 1);
        chk("R1 we_n/oe_n in reset", int'({dram_we_n, dram_oe_n}), 3);
        chk("R1 dq_oe/rd_valid in reset", int'({dram_dq_oe, rd_valid}), 0);
        chk("R1 ready in reset", int'(req_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        // page hits in row 5, mixed read and write
        send(5, 1, 0, 0);
        send(5, 2, 0, 0);
        send(5, 3, 1, 16'hbeef);
        // row change
        send(9, 7, 0, 0);
        // long same-row run that must hit the row-open limit
        for (int i = 0; i < 8; i++) send(2, 10 + i, 0, 0);
        repeat (12) @(negedge clk);
        send(3, 0, 1, 16'h5a5a);
        send(3, 1, 1, 16'h0f0f);
        send(3, 1, 0, 0);
        repeat (30) @(negedge clk);
        #1;
        chk("R7 row strobe falls (limit forces reopen)", ras_falls, 5);
        chk("R5 column strobe falls", cas_falls, NREQ);
        chk("R9 read pulses", rd_pulses, 12);
        chk("R6 idle after drain", int'(dram_ras_n), 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule